// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is a small memory-mapped register window through which a host processor hands commands to an embedded service controller. The host writes any payload into a 16-byte outbound buffer. It then issues a single 32-bit command word. That one write latches the word, marks the mailbox busy and fires a one-cycle request pulse toward the controller. The command word carries an opcode, a sub-command id, a payload length in bytes and a flag asking for a completion interrupt.

The service controller reads the latched word and the outbound buffer through its own side ports. It leaves any reply in a 16-byte inbound buffer and finishes with a one-cycle done strobe that carries an error flag and an 8-bit error code. The host polls a status register until busy drops, then inspects the error bit and code. It can read the reply either as whole words or byte by byte. If the command asked for it, completion also gives the host a one-cycle interrupt pulse that needs no clearing.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset the mailbox is idle with error flag, error code, the latched command and both buffers cleared. A status read returns only the initiator id in bits [15:8], and both interrupt outputs are low.
- R2: A host write to offset 0x00 while idle latches the write data onto `svcCmdWord` and sets busy. In the next cycle it raises `svcCmdIrq` for exactly one cycle.
- R3: A status read at offset 0x04 returns the following fields, with all other bits zero:
  - bit 0: busy
  - bit 1: error flag
  - bits [7:4]: the sub-command id taken from bits [15:12] of the latched command
  - bits [15:8]: the `INIT_ID` parameter
  - bits [23:16]: the error code
- R4: A write to offset 0x00 while busy is ignored. `svcCmdWord` keeps its value, busy stays set and `svcCmdIrq` does not pulse.
- R5: A done strobe while busy clears busy and loads the error flag and code from `svcErr`/`svcErrCode`. Issuing a new command clears the error flag and code to zero.
- R6: `hostIrq` pulses for exactly one cycle, in the cycle after an accepted done strobe, if and only if bit 8 of the latched command was set.
- R7: A done strobe while idle changes nothing. Status is unchanged and `hostIrq` stays low.
- R8: A host write to offset 0x80+4k stores word k of the outbound buffer, which the controller sees on `svcWbufData` when `svcWbufIdx` is k. Host reads in the 0x80–0x8F range return zero.
- R9: The controller writes inbound word k with `svcRbufWrEn`. A host word read at 0x90+4k returns that word. A byte read (`hostByteRd`=1) at 0x90+n returns byte n, little-endian (word n/4, bits [8(n%4)+7 : 8(n%4)]), zero-extended.
- R10: `hostRdData` is registered. It loads in the cycle after `hostRdEn` and holds its value otherwise. Reads of offset 0x00 or of any unmapped offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | 8 | Host byte offset within the window |
| hostWrEn | input | 1 | Host write strobe |
| hostWrData | input | 32 | Host write data |
| hostRdEn | input | 1 | Host read strobe |
| hostByteRd | input | 1 | 1 selects a byte read of the inbound buffer |
| hostRdData | output | 32 | Registered host read data |
| hostIrq | output | 1 | One-cycle completion interrupt to the host |
| svcCmdIrq | output | 1 | One-cycle new-command pulse to the controller |
| svcCmdWord | output | 32 | Latched command word |
| svcWbufIdx | input | 2 | Outbound buffer word index for the controller |
| svcWbufData | output | 32 | Outbound buffer word at `svcWbufIdx` |
| svcRbufWrEn | input | 1 | Controller write strobe for the inbound buffer |
| svcRbufIdx | input | 2 | Inbound buffer word index |
| svcRbufData | input | 32 | Inbound buffer write data |
| svcDone | input | 1 | Command completion strobe |
| svcErr | input | 1 | Error flag accompanying `svcDone` |
| svcErrCode | input | 8 | Error code accompanying `svcDone` |

## Verification
A corrupted busy bit shows at the ports within one cycle. It appears either as a missing or repeated `svcCmdIrq` after a command write, or as a stale busy bit on the next status read. A wrongly latched command or error field appears in the very next status read as a wrong sub-command id, error flag or code. Buffer indexing faults show on the first read of a mismatched word or byte lane. The sweep therefore issues one command per sub-command value, each with its own payload length, interrupt request and error outcome. Around every command it reads the status back and also tries a second command write while busy.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;
  localparam int MBOX_AW   = 8;
  localparam int BUF_WORDS = 4;
  localparam int IDX_W     = $clog2(BUF_WORDS);

  localparam logic [MBOX_AW-1:0] CMD_OFS  = 8'h00;
  localparam logic [MBOX_AW-1:0] STAT_OFS = 8'h04;
  localparam logic [MBOX_AW-1:0] WBUF_OFS = 8'h80;
  localparam logic [MBOX_AW-1:0] RBUF_OFS = 8'h90;

  localparam int IOC_BIT = 8;
  localparam int SUB_LSB = 12;

  typedef struct packed {
    logic issue;
    logic finish;
    logic wbufWr;
    logic rdLoad;
  } mbox_strobe_t;
endpackage

// File: rtl/ipc_mbox_ctrl.sv
module ipc_mbox_ctrl
  import ipc_mbox_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [MBOX_AW-1:0] hostAddr,
  input  logic               hostWrEn,
  input  logic               hostRdEn,
  input  logic               iocBit,
  input  logic               svcDone,
  output mbox_strobe_t       strb,
  output logic               busy,
  output logic               svcCmdIrq,
  output logic               hostIrq
);
  logic iocHeld;
  logic inWbuf;

  assign inWbuf      = (hostAddr[MBOX_AW-1:4] == WBUF_OFS[MBOX_AW-1:4]);
  assign strb.issue  = hostWrEn && (hostAddr == CMD_OFS) && !busy;
  assign strb.finish = svcDone && busy;
  assign strb.wbufWr = hostWrEn && inWbuf;
  assign strb.rdLoad = hostRdEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      iocHeld   <= 1'b0;
      svcCmdIrq <= 1'b0;
      hostIrq   <= 1'b0;
    end else begin
      svcCmdIrq <= strb.issue;
      hostIrq   <= strb.finish && iocHeld;
      if (strb.issue) begin
        busy    <= 1'b1;
        iocHeld <= iocBit;
      end else if (strb.finish) begin
        busy    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ipc_mbox_dp.sv
module ipc_mbox_dp
  import ipc_mbox_pkg::*;
#(
  parameter logic [7:0] INIT_ID = 8'hA5
) (
  input  logic               clk,
  input  logic               rstN,
  input  mbox_strobe_t       strb,
  input  logic               busy,
  input  logic [MBOX_AW-1:0] hostAddr,
  input  logic [31:0]        hostWrData,
  input  logic               hostByteRd,
  output logic [31:0]        hostRdData,
  output logic [31:0]        svcCmdWord,
  input  logic [IDX_W-1:0]   svcWbufIdx,
  output logic [31:0]        svcWbufData,
  input  logic               svcRbufWrEn,
  input  logic [IDX_W-1:0]   svcRbufIdx,
  input  logic [31:0]        svcRbufData,
  input  logic               svcErr,
  input  logic [7:0]         svcErrCode
);
  logic [31:0] wbufQ [BUF_WORDS];
  logic [31:0] rbufQ [BUF_WORDS];
  logic        errFlag;
  logic [7:0]  errCode;
  logic [31:0] statusWord;
  logic [31:0] rbufWord;
  logic [31:0] rbufShift;
  logic [31:0] rdNext;
  logic [IDX_W-1:0] hostIdx;

  assign hostIdx = hostAddr[IDX_W+1:2];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      svcCmdWord <= '0;
      errFlag    <= 1'b0;
      errCode    <= '0;
    end else if (strb.issue) begin
      svcCmdWord <= hostWrData;
      errFlag    <= 1'b0;
      errCode    <= '0;
    end else if (strb.finish) begin
      errFlag    <= svcErr;
      errCode    <= svcErrCode;
    end
  end

  for (genvar gi = 0; gi < BUF_WORDS; gi++) begin : g_buf
    always_ff @(posedge clk) begin
      if (!rstN) begin
        wbufQ[gi] <= '0;
        rbufQ[gi] <= '0;
      end else begin
        if (strb.wbufWr && hostIdx == IDX_W'(gi)) wbufQ[gi] <= hostWrData;
        if (svcRbufWrEn && svcRbufIdx == IDX_W'(gi)) rbufQ[gi] <= svcRbufData;
      end
    end
  end

  assign svcWbufData = wbufQ[svcWbufIdx];
  assign statusWord  = {8'h00, errCode, INIT_ID, svcCmdWord[SUB_LSB+3:SUB_LSB],
                        2'b00, errFlag, busy};
  assign rbufWord    = rbufQ[hostIdx];
  assign rbufShift   = rbufWord >> {hostAddr[1:0], 3'b000};

  always_comb begin
    rdNext = '0;
    if (hostAddr == STAT_OFS)
      rdNext = statusWord;
    else if (hostAddr[MBOX_AW-1:4] == RBUF_OFS[MBOX_AW-1:4])
      rdNext = hostByteRd ? {24'h0, rbufShift[7:0]} : rbufWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            hostRdData <= '0;
    else if (strb.rdLoad) hostRdData <= rdNext;
  end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import ipc_mbox_pkg::*;
#(
  parameter logic [7:0] INIT_ID = 8'hA5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       hostAddr,
  input  logic             hostWrEn,
  input  logic [31:0]      hostWrData,
  input  logic             hostRdEn,
  input  logic             hostByteRd,
  output logic [31:0]      hostRdData,
  output logic             hostIrq,
  output logic             svcCmdIrq,
  output logic [31:0]      svcCmdWord,
  input  logic [1:0]       svcWbufIdx,
  output logic [31:0]      svcWbufData,
  input  logic             svcRbufWrEn,
  input  logic [1:0]       svcRbufIdx,
  input  logic [31:0]      svcRbufData,
  input  logic             svcDone,
  input  logic             svcErr,
  input  logic [7:0]       svcErrCode
);
  mbox_strobe_t strb;
  logic         busy;

  ipc_mbox_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .hostAddr  (hostAddr),
    .hostWrEn  (hostWrEn),
    .hostRdEn  (hostRdEn),
    .iocBit    (hostWrData[IOC_BIT]),
    .svcDone   (svcDone),
    .strb      (strb),
    .busy      (busy),
    .svcCmdIrq (svcCmdIrq),
    .hostIrq   (hostIrq)
  );

  ipc_mbox_dp #(.INIT_ID(INIT_ID)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .busy        (busy),
    .hostAddr    (hostAddr),
    .hostWrData  (hostWrData),
    .hostByteRd  (hostByteRd),
    .hostRdData  (hostRdData),
    .svcCmdWord  (svcCmdWord),
    .svcWbufIdx  (svcWbufIdx),
    .svcWbufData (svcWbufData),
    .svcRbufWrEn (svcRbufWrEn),
    .svcRbufIdx  (svcRbufIdx),
    .svcRbufData (svcRbufData),
    .svcErr      (svcErr),
    .svcErrCode  (svcErrCode)
  );
endmodule

// File: rtl/ipc_mbox_chk.sv
module ipc_mbox_chk (
  input logic        clk,
  input logic        rstN,
  input logic [7:0]  hostAddr,
  input logic        hostWrEn,
  input logic        svcDone,
  input logic        busy,
  input logic        svcCmdIrq,
  input logic        hostIrq,
  input logic [31:0] svcCmdWord
);
  logic cmdWrite;
  assign cmdWrite = hostWrEn && (hostAddr == 8'h00);

  AST_ISSUE_RAISES: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrite && !busy) |=> (busy && svcCmdIrq)); // R2
  AST_CMD_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    svcCmdIrq |=> !svcCmdIrq); // R2
  AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrite && busy) |=> (!svcCmdIrq && $stable(svcCmdWord))); // R4
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (busy && svcDone) |=> !busy); // R5
  AST_HOST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    hostIrq |-> $past(busy && svcDone)); // R6
  AST_IDLE_DONE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && svcDone && !cmdWrite) |=> (!busy && !hostIrq)); // R7
endmodule

bind ipc_mailbox ipc_mbox_chk u_chk (.*);

// File: tb/tb_ipc_mailbox.sv
`timescale 1ns/1ps
module tb_ipc_mailbox;
  localparam logic [7:0] INIT = 8'hA5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  hostAddr = '0;
  logic        hostWrEn = 1'b0;
  logic [31:0] hostWrData = '0;
  logic        hostRdEn = 1'b0;
  logic        hostByteRd = 1'b0;
  logic [31:0] hostRdData;
  logic        hostIrq;
  logic        svcCmdIrq;
  logic [31:0] svcCmdWord;
  logic [1:0]  svcWbufIdx = '0;
  logic [31:0] svcWbufData;
  logic        svcRbufWrEn = 1'b0;
  logic [1:0]  svcRbufIdx = '0;
  logic [31:0] svcRbufData = '0;
  logic        svcDone = 1'b0;
  logic        svcErr = 1'b0;
  logic [7:0]  svcErrCode = '0;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ipc_mailbox #(.INIT_ID(INIT)) dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] statusOf(logic bsy, logic err, logic [3:0] sub, logic [7:0] code);
    return {8'h00, code, INIT, sub, 2'b00, err, bsy};
  endfunction

  task automatic hostWrite(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    hostAddr = a; hostWrData = d; hostWrEn = 1'b1;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic hostRead(logic [7:0] a, logic byteRd, output logic [31:0] d);
    @(negedge clk);
    hostAddr = a; hostByteRd = byteRd; hostRdEn = 1'b1;
    @(negedge clk);
    hostRdEn = 1'b0; hostByteRd = 1'b0;
    d = hostRdData;
  endtask

  task automatic svcFinish(logic err, logic [7:0] code);
    @(negedge clk);
    svcDone = 1'b1; svcErr = err; svcErrCode = code;
    @(negedge clk);
    svcDone = 1'b0; svcErr = 1'b0; svcErrCode = '0;
  endtask

  task automatic svcRbufWrite(logic [1:0] idx, logic [31:0] d);
    @(negedge clk);
    svcRbufWrEn = 1'b1; svcRbufIdx = idx; svcRbufData = d;
    @(negedge clk);
    svcRbufWrEn = 1'b0;
  endtask

  function automatic logic [7:0] byteVal(int n);
    return 8'(8'h30 + n * 7);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] cmd;
    logic [31:0] lastStat;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    check("R1", {30'h0, hostIrq, svcCmdIrq}, 32'h0, "irqs after reset");
    check("R1", svcCmdWord, 32'h0, "latched command after reset");
    hostRead(8'h04, 1'b0, rd);
    check("R1", rd, statusOf(1'b0, 1'b0, 4'h0, 8'h00), "status after reset");
    for (int k = 0; k < 4; k++) begin
      svcWbufIdx = 2'(k);
      #1 check("R1", svcWbufData, 32'h0, "outbound word after reset");
      hostRead(8'(8'h90 + 4 * k), 1'b0, rd);
      check("R1", rd, 32'h0, "inbound word after reset");
    end

    // R8 outbound buffer
    for (int k = 0; k < 4; k++) hostWrite(8'(8'h80 + 4 * k), 32'h1357_9BDF ^ (32'h0101_0101 * (k + 1)));
    for (int k = 0; k < 4; k++) begin
      svcWbufIdx = 2'(k);
      #1 check("R8", svcWbufData, 32'h1357_9BDF ^ (32'h0101_0101 * (k + 1)), "outbound word");
      hostRead(8'(8'h80 + 4 * k), 1'b0, rd);
      check("R8", rd, 32'h0, "outbound window reads zero");
    end

    // R9 inbound buffer, word and byte reads
    for (int k = 0; k < 4; k++)
      svcRbufWrite(2'(k), {byteVal(4*k+3), byteVal(4*k+2), byteVal(4*k+1), byteVal(4*k)});
    for (int k = 0; k < 4; k++) begin
      hostRead(8'(8'h90 + 4 * k), 1'b0, rd);
      check("R9", rd, {byteVal(4*k+3), byteVal(4*k+2), byteVal(4*k+1), byteVal(4*k)}, "inbound word read");
    end
    for (int n = 0; n < 16; n++) begin
      hostRead(8'(8'h90 + n), 1'b1, rd);
      check("R9", rd, {24'h0, byteVal(n)}, "inbound byte read");
    end

    // R10 command and unmapped reads, hold behaviour
    hostRead(8'h00, 1'b0, rd);
    check("R10", rd, 32'h0, "command offset reads zero");
    hostRead(8'h40, 1'b0, rd);
    check("R10", rd, 32'h0, "unmapped offset reads zero");
    hostRead(8'h04, 1'b0, lastStat);

    // Sweep over every sub-command id
    for (int s = 0; s < 16; s++) begin
      logic ioc;
      logic err;
      logic [7:0] code;
      ioc  = s[0];
      err  = (s % 3 == 0);
      code = 8'(s * 9 + 1);
      cmd  = {8'h00, 8'(s * 3), 4'(s), 3'b000, ioc, 8'(8'hF0 + s)};
      hostWrite(8'h00, cmd);
      check("R2", {31'h0, svcCmdIrq}, 32'h1, "service request pulse");
      check("R2", svcCmdWord, cmd, "latched command");
      if (s == 0) check("R10", hostRdData, lastStat, "read data held without read strobe");
      @(negedge clk);
      check("R2", {31'h0, svcCmdIrq}, 32'h0, "service request is one cycle");
      hostRead(8'h04, 1'b0, rd);
      check("R3", rd, statusOf(1'b1, 1'b0, 4'(s), 8'h00), "status while busy");
      hostWrite(8'h00, ~cmd);
      check("R4", {31'h0, svcCmdIrq}, 32'h0, "no request on busy write");
      check("R4", svcCmdWord, cmd, "busy write ignored");
      svcFinish(err, code);
      check("R6", {31'h0, hostIrq}, {31'h0, ioc}, "host completion pulse");
      @(negedge clk);
      check("R6", {31'h0, hostIrq}, 32'h0, "host pulse is one cycle");
      hostRead(8'h04, 1'b0, rd);
      check("R5", rd, statusOf(1'b0, err, 4'(s), code), "status after done");
    end

    // R7 done while idle
    svcFinish(1'b0, 8'h77);
    check("R7", {31'h0, hostIrq}, 32'h0, "no host pulse on idle done");
    hostRead(8'h04, 1'b0, rd);
    check("R7", rd, statusOf(1'b0, 1'b1, 4'hF, 8'(15 * 9 + 1)), "status unchanged on idle done");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule